// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block watches one serial receive line of a LIN bus and recognises frame headers: a long dominant break, a delimiter, a sync character and an identifier character. A sample tick at sixteen times the bit rate drives all timing. Each bit is decided by a majority vote over three samples at the middle of the bit. The identifier is handed over as a received byte. A time-out measured from the first falling edge of the break stops a header that runs too long.

The receiver can be put into a muted state. While muted, ordinary characters are dropped. The receiver leaves that state only when a complete, well-formed header has been received within the time budget. A time-out takes priority over completion, so a header that runs out of time on the very tick its identifier stop bit is decided does not wake the receiver. Three sticky flags (header seen, header error, byte ready) drive one masked interrupt line. A single strobe clears all three flags.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset `muted` is 1, `hdr_det`, `hdr_err`, `rx_ready` and `irq` are 0 and `rx_data` is 0x00.
- R2: Each bit spans 16 sample ticks. Samples are counted from 0 at the first low sample of the start bit, and the bit value is the majority of samples 7, 8 and 9. A start bit whose majority is high is dropped with no effect on flags or data.
- R3: A break is a falling edge followed by a character that decodes as all-zero data with a low stop bit, with the line held low for at least 13 bit times (208 ticks) before it returns high. A shorter low period raises no flag.
- R4: The character after the break must be 0x55 with a high stop bit. Any other value sets `hdr_err`, leaves `muted` unchanged and sends the receiver back to wait for a break.
- R5: When the identifier stop bit is decided (sample 9 of that bit) high, `hdr_det` and `rx_ready` are set, `rx_data` takes the identifier and `muted` is cleared at the same clock edge.
- R6: If 57 whole bit times (912 ticks) elapse since the break's first low sample before the identifier stop-bit decision, `hdr_err` is set, `hdr_det` and `rx_ready` stay clear and `muted` stays set. A time-out on the same tick as that decision takes priority.
- R7: A `mute_req` pulse sets `muted`. While muted, characters outside a header leave `rx_ready` and `rx_data` untouched. While not muted, a character with a high stop bit is loaded into `rx_data` and sets `rx_ready`.
- R8: `hdr_det`, `hdr_err` and `rx_ready` stay set until `flag_clr` is high at a clock edge. That edge clears all three.
- R9: `irq` is high whenever an enabled flag is set. In `irq_en`, bit 0 enables `hdr_det`, bit 1 enables `hdr_err` and bit 2 enables `rx_ready`.
- R10: Receive state advances only on clocks where `samp_tick` is high, so a header sampled once every third clock decodes the same as one sampled every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_tick | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial receive line, high when idle |
| flag_clr | input | 1 | Clears all three flags |
| mute_req | input | 1 | Puts the receiver into the muted state |
| irq_en | input | 3 | Interrupt enables: bit 0 header seen, bit 1 error, bit 2 byte ready |
| hdr_det | output | 1 | Header received flag |
| hdr_err | output | 1 | Header error flag (bad sync or time-out) |
| rx_ready | output | 1 | Received byte available flag |
| rx_data | output | 8 | Last accepted byte or identifier |
| muted | output | 1 | Receiver is in the muted state |
| irq | output | 1 | Masked OR of the flags |

## Verification
Every flag and `rx_data` change at the clock edge that carries tick 9 of a stop bit. `hdr_err` from a time-out changes at the edge carrying tick 912 after the break's first low sample. `flag_clr` takes effect at the next edge, and `irq` follows the flags with no further delay. The bench drives the line one sample per tick window. It reads results on falling edges only after a stop bit and a stretch of idle samples have passed, so every due edge is already behind it. The time-out cases set the idle gap before the identifier so that its stop-bit decision falls one tick before, on, or one tick after tick 912.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BRKW = 2'd1,
        ST_SYNC = 2'd2,
        ST_ID   = 2'd3
    } hdr_state_e;

    localparam int NFLAG = 3;
endpackage

// File: rtl/lin_char_rx.sv
module lin_char_rx #(
    parameter int OVS   = 16,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic             arm,
    input  logic             abort,
    output logic             start,
    output logic             done,
    output logic             noise,
    output logic             stop_ok,
    output logic [DBITS-1:0] data
);
    localparam int SW  = $clog2(OVS);
    localparam int BW  = $clog2(DBITS + 2);
    localparam int MID = OVS / 2;

    typedef struct packed {
        logic             busy;
        logic             prev;
        logic [SW-1:0]    scnt;
        logic [BW-1:0]    bidx;
        logic [1:0]       ones;
        logic [DBITS-1:0] shreg;
    } crx_s;

    crx_s q, d;
    logic maj;

    always_comb begin
        d       = q;
        start   = 1'b0;
        done    = 1'b0;
        noise   = 1'b0;
        stop_ok = 1'b0;
        maj     = (q.ones + {1'b0, rxd}) >= 2'd2;
        if (tick) begin
            d.prev = rxd;
            if (abort) begin
                d.busy = 1'b0;
            end else if (!q.busy) begin
                if (arm && q.prev && !rxd) begin
                    d.busy = 1'b1;
                    d.scnt = SW'(1);
                    d.bidx = '0;
                    start  = 1'b1;
                end
            end else begin
                if (q.scnt == SW'(OVS - 1)) begin
                    d.scnt = '0;
                    d.bidx = q.bidx + BW'(1);
                end else begin
                    d.scnt = q.scnt + SW'(1);
                end
                if (q.scnt == SW'(MID - 1)) d.ones = {1'b0, rxd};
                if (q.scnt == SW'(MID))     d.ones = q.ones + {1'b0, rxd};
                if (q.scnt == SW'(MID + 1)) begin
                    if (q.bidx == '0) begin
                        if (maj) begin
                            noise  = 1'b1;
                            d.busy = 1'b0;
                        end
                    end else if (q.bidx == BW'(DBITS + 1)) begin
                        done    = 1'b1;
                        stop_ok = maj;
                        d.busy  = 1'b0;
                    end else begin
                        d.shreg = {maj, q.shreg[DBITS-1:1]};
                    end
                end
            end
        end
    end

    assign data = q.shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lin_hdr_timer.sv
module lin_hdr_timer #(
    parameter int OVS      = 16,
    parameter int TMO_BITS = 57
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic stop,
    output logic tmo
);
    localparam int SW = $clog2(OVS);
    localparam int TW = $clog2(TMO_BITS + 1);

    typedef struct packed {
        logic          run;
        logic [SW-1:0] sub;
        logic [TW-1:0] bits;
    } tmr_s;

    tmr_s q, d;

    assign tmo = q.run && tick && (q.bits == TW'(TMO_BITS));

    always_comb begin
        d = q;
        if (start) begin
            d.run  = 1'b1;
            d.sub  = SW'(1);
            d.bits = '0;
        end else if (stop || tmo) begin
            d.run = 1'b0;
        end else if (tick && q.run) begin
            if (q.sub == SW'(OVS - 1)) begin
                d.sub  = '0;
                d.bits = q.bits + TW'(1);
            end else begin
                d.sub = q.sub + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int          OVS      = 16,
    parameter int          BRK_BITS = 13,
    parameter int          TMO_BITS = 57,
    parameter logic [7:0]  SYNC_PAT = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_tick,
    input  logic             rxd,
    input  logic             flag_clr,
    input  logic             mute_req,
    input  logic [NFLAG-1:0] irq_en,
    output logic             hdr_det,
    output logic             hdr_err,
    output logic             rx_ready,
    output logic [7:0]       rx_data,
    output logic             muted,
    output logic             irq
);
    localparam int BRK_SAMP = BRK_BITS * OVS;
    localparam int LW       = $clog2(BRK_SAMP + 1);

    typedef struct packed {
        hdr_state_e  state;
        logic        muted;
        logic        det;
        logic        err;
        logic        rdy;
        logic [7:0]  data;
        logic [LW-1:0] lowrun;
    } top_s;

    top_s q, d;

    logic       chr_arm, chr_start, chr_done, chr_noise, chr_stop;
    logic [7:0] chr_data;
    logic       tmr_start, tmr_stop, tmo;
    logic       brk_cand;

    lin_char_rx #(.OVS(OVS), .DBITS(8)) u_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (samp_tick),
        .rxd     (rxd),
        .arm     (chr_arm),
        .abort   (tmo),
        .start   (chr_start),
        .done    (chr_done),
        .noise   (chr_noise),
        .stop_ok (chr_stop),
        .data    (chr_data)
    );

    lin_hdr_timer #(.OVS(OVS), .TMO_BITS(TMO_BITS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (samp_tick),
        .start (tmr_start),
        .stop  (tmr_stop),
        .tmo   (tmo)
    );

    assign chr_arm  = (q.state != ST_BRKW);
    assign brk_cand = chr_done && (chr_data == 8'h00) && !chr_stop;

    always_comb begin
        d         = q;
        tmr_start = 1'b0;
        tmr_stop  = 1'b0;
        if (flag_clr) begin
            d.det = 1'b0;
            d.err = 1'b0;
            d.rdy = 1'b0;
        end
        if (mute_req) d.muted = 1'b1;
        if (samp_tick) begin
            if (rxd)                           d.lowrun = '0;
            else if (q.lowrun < LW'(BRK_SAMP)) d.lowrun = q.lowrun + LW'(1);
        end
        if (tmo) begin
            d.state = ST_IDLE;
            d.err   = 1'b1;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (chr_start) tmr_start = 1'b1;
                    if (chr_noise) tmr_stop  = 1'b1;
                    if (brk_cand) begin
                        d.state = ST_BRKW;
                    end else if (chr_done) begin
                        tmr_stop = 1'b1;
                        if (!q.muted && chr_stop) begin
                            d.data = chr_data;
                            d.rdy  = 1'b1;
                        end
                    end
                end
                ST_BRKW: begin
                    if (samp_tick && rxd) begin
                        if (q.lowrun >= LW'(BRK_SAMP)) begin
                            d.state = ST_SYNC;
                        end else begin
                            d.state  = ST_IDLE;
                            tmr_stop = 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (chr_done) begin
                        if (chr_stop && chr_data == SYNC_PAT) begin
                            d.state = ST_ID;
                        end else begin
                            d.state  = ST_IDLE;
                            d.err    = 1'b1;
                            tmr_stop = 1'b1;
                        end
                    end
                end
                ST_ID: begin
                    if (chr_done) begin
                        d.state  = ST_IDLE;
                        tmr_stop = 1'b1;
                        if (chr_stop) begin
                            d.det   = 1'b1;
                            d.rdy   = 1'b1;
                            d.data  = chr_data;
                            d.muted = 1'b0;
                        end else begin
                            d.err = 1'b1;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.muted <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hdr_det  = q.det;
    assign hdr_err  = q.err;
    assign rx_ready = q.rdy;
    assign rx_data  = q.data;
    assign muted    = q.muted;
    assign irq      = |({q.rdy, q.err, q.det} & irq_en);
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mute_req,
    input logic       flag_clr,
    input logic       muted,
    input logic       hdr_det,
    input logic       hdr_err,
    input logic       rx_ready,
    input logic [7:0] rx_data
);
    // R5: leaving the muted state always comes with a header and a byte
    a_r5_wake_with_header: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(muted) |-> (hdr_det && rx_ready));

    // R7: muted is only entered on request
    a_r7_mute_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(muted) |-> $past(mute_req));

    // R7: the byte register only moves when a byte is flagged
    a_r7_data_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_ready);

    // R6: a header is never both accepted and failed at one edge
    a_r6_det_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(hdr_det) && $rose(hdr_err)));

    // R8: flags hold until cleared
    a_r8_det_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_det && !flag_clr) |=> hdr_det);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_err && !flag_clr) |=> hdr_err);
    a_r8_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !flag_clr) |=> rx_ready);
endmodule

bind lin_hdr_rx lin_hdr_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mute_req (mute_req),
    .flag_clr (flag_clr),
    .muted    (muted),
    .hdr_det  (hdr_det),
    .hdr_err  (hdr_err),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
);

// File: tb/tb_lin_hdr_rx.sv
module tb_lin_hdr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       flag_clr = 1'b0;
    logic       mute_req = 1'b0;
    logic [2:0] irq_en = 3'b000;
    logic       hdr_det, hdr_err, rx_ready, muted, irq;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int tpc = 1;
    int tcnt = 0;
    bit finished = 0;

    lin_hdr_rx dut (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
        .flag_clr(flag_clr), .mute_req(mute_req), .irq_en(irq_en),
        .hdr_det(hdr_det), .hdr_err(hdr_err), .rx_ready(rx_ready),
        .rx_data(rx_data), .muted(muted), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tcnt      = (tcnt + 1 >= tpc) ? 0 : tcnt + 1;
        samp_tick = (tcnt == 0);
    end

    typedef struct packed {
        logic [7:0]  brk_bits;
        logic [15:0] gap;
        logic [7:0]  sync;
        logic [7:0]  id;
        logic        exp_det;
        logic        exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd13, 16'd0,   8'h55, 8'h3A, 1'b1, 1'b0},  // R5 minimum break
        '{8'd20, 16'd16,  8'h55, 8'hC5, 1'b1, 1'b0},  // R5 longer break, gap
        '{8'd12, 16'd0,   8'h55, 8'h11, 1'b0, 1'b0},  // R3 short break
        '{8'd13, 16'd0,   8'h54, 8'h22, 1'b0, 1'b1},  // R4 bad sync
        '{8'd13, 16'd374, 8'h55, 8'h6B, 1'b1, 1'b0},  // R6 one tick early
        '{8'd13, 16'd375, 8'h55, 8'h6B, 1'b0, 1'b1},  // R6 same tick
        '{8'd13, 16'd376, 8'h55, 8'h6B, 1'b0, 1'b1},  // R6 one tick late
        '{8'd60, 16'd0,   8'h55, 8'h44, 1'b0, 1'b1}   // R6 break too long
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v);
        rxd = v;
        repeat (tpc) @(negedge clk);
    endtask

    task automatic drive_n(input logic v, input int n);
        for (int i = 0; i < n; i++) drive(v);
    endtask

    task automatic send_char(input logic [7:0] dat, input logic stopv,
                             input int fbit, input logic [15:0] fmask);
        logic v;
        for (int b = 0; b < 10; b++) begin
            if (b == 0)      v = 1'b0;
            else if (b == 9) v = stopv;
            else             v = dat[b-1];
            for (int s = 0; s < 16; s++)
                drive(v ^ ((b == fbit) ? fmask[s] : 1'b0));
        end
    endtask

    task automatic send_header(input int brk, input int gap,
                               input logic [7:0] sy, input logic [7:0] id);
        drive_n(1'b0, brk * 16);
        drive_n(1'b1, 16);
        send_char(sy, 1'b1, -1, 16'h0);
        drive_n(1'b1, gap);
        send_char(id, 1'b1, -1, 16'h0);
        drive_n(1'b1, 32);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic prep();
        drive_n(1'b1, 32);
        mute_req = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk);
        mute_req = 1'b0;
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 muted", muted, 1);
        chk("R1 flags", {hdr_det, hdr_err, rx_ready, irq}, 0);
        chk("R1 data", rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            prep();
            send_header(int'(VECS[i].brk_bits), int'(VECS[i].gap), VECS[i].sync, VECS[i].id);
            chk($sformatf("R5/R6 vec%0d det", i), hdr_det, VECS[i].exp_det);
            chk($sformatf("R4/R6 vec%0d err", i), hdr_err, VECS[i].exp_err);
            chk($sformatf("R5/R7 vec%0d ready", i), rx_ready, VECS[i].exp_det);
            chk($sformatf("R5/R6 vec%0d muted", i), muted, !VECS[i].exp_det);
            if (VECS[i].exp_det) chk($sformatf("R5 vec%0d id", i), rx_data, VECS[i].id);
        end

        // R2 glitch on the line before the sync start bit is dropped
        prep();
        drive_n(1'b0, 13 * 16);
        drive_n(1'b1, 16);
        drive_n(1'b0, 3);
        drive_n(1'b1, 29);
        send_char(8'h55, 1'b1, -1, 16'h0);
        send_char(8'h9C, 1'b1, -1, 16'h0);
        drive_n(1'b1, 32);
        chk("R2 noise start det", hdr_det, 1);
        chk("R2 noise start id", rx_data, 8'h9C);
        chk("R2 noise start err", hdr_err, 0);

        // R7 unmuted byte reception
        pulse_clr();
        send_char(8'hA7, 1'b1, -1, 16'h0);
        drive_n(1'b1, 16);
        chk("R7 unmuted ready", rx_ready, 1);
        chk("R7 unmuted data", rx_data, 8'hA7);

        // R2 one disturbed sample of data bit 3 is outvoted
        pulse_clr();
        send_char(8'h5A, 1'b1, 4, 16'h0080);
        drive_n(1'b1, 16);
        chk("R2 single sample outvoted", rx_data, 8'h5A);

        // R2 two disturbed samples of data bit 3 flip it
        pulse_clr();
        send_char(8'h5A, 1'b1, 4, 16'h0300);
        drive_n(1'b1, 16);
        chk("R2 two samples flip bit", rx_data, 8'h52);

        // R7 muted receiver ignores bytes
        pulse_clr();
        mute_req = 1'b1;
        @(negedge clk);
        mute_req = 1'b0;
        chk("R7 mute request", muted, 1);
        send_char(8'h3C, 1'b1, -1, 16'h0);
        drive_n(1'b1, 16);
        chk("R7 muted ready", rx_ready, 0);
        chk("R7 muted data", rx_data, 8'h52);

        // R10 one tick every third clock
        drive_n(1'b1, 4);
        tpc = 3;
        prep();
        send_header(13, 0, 8'h55, 8'h5E);
        chk("R10 slow tick det", hdr_det, 1);
        chk("R10 slow tick id", rx_data, 8'h5E);
        tpc = 1;
        drive_n(1'b1, 8);

        // R9 interrupt masking with header and ready flags set
        irq_en = 3'b010;
        #1 chk("R9 error only enabled", irq, 0);
        irq_en = 3'b001;
        #1 chk("R9 header enabled", irq, 1);
        irq_en = 3'b100;
        #1 chk("R9 ready enabled", irq, 1);

        // R8 flags hold, then clear together
        repeat (40) @(negedge clk);
        chk("R8 det holds", {hdr_det, rx_ready}, 2'b11);
        pulse_clr();
        chk("R8 clear all", {hdr_det, hdr_err, rx_ready}, 0);
        chk("R9 irq after clear", irq, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule